// File: doc/BRIEF.md
# SDRAM Low-Power Entry Controller

This block sits next to an SDRAM command sequencer. It decides when the memory should go into a low-power state once transfers stop. A programmable idle timeout selects the delay. The timeout can mean entry at once, entry after a short or a long count of idle clocks, or no entry at all. A new transfer clears the count and drops any entry request in the same cycle.

The block also keeps three mode settings for the extended mode register: refresh-interval compensation for self refresh, output drive strength, and active power-down exit speed. If software changes any of them after initialization, the block flags a pending extended mode register write and asks the sequencer to perform it. The values it offers are always the latest ones stored. A slot-policy bit decides when the request is raised. With the bit at 0, the request comes when the idle timeout expires, just ahead of low-power entry, and entry waits for the grant. With the bit at 1, the request rides on a refresh strobe that arrives while a transfer is in progress.

Top module: `lp_entry_ctrl`

## Requirements
- R1: After reset the stored fields are: timeout code 00, compensation 0, drive strength 0, exit speed 1 (slow; 0 means fast), slot policy 0. After reset, `mode_upd_pending`, `mode_upd_req` and `lp_enter` are low.
- R2: With timeout code 00, after init, `lp_enter` is high in every cycle in which `xfer_busy` is low.
- R3: With code 01, `lp_enter` rises once `xfer_busy` has been sampled low at 64 consecutive rising clock edges. With code 10 it needs 128 such edges. One edge fewer keeps it low.
- R4: Timeout code 11 keeps `lp_enter` low however long the bus stays idle.
- R5: `lp_enter` is low in any cycle with `xfer_busy` high. A transfer restarts the idle count from zero.
- R6: A register write that changes compensation, drive strength or exit speed, made while `init_done` is high, sets `mode_upd_pending` at the next clock edge. A write that leaves all three unchanged does not set it. This includes a write that only changes the timeout or the policy.
- R7: Before `init_done`, register writes still update the stored fields but never set `mode_upd_pending`. `lp_enter` stays low.
- R8: Several changes made before the grant produce one pending update. The `emr_*` outputs carry the latest written values.
- R9: With policy 0 and an update pending, `mode_upd_req` is high exactly when the idle timeout is met. `lp_enter` is held low until the grant clears the pending flag.
- R10: With policy 1 and an update pending, `mode_upd_req` goes high after a `ref_req` strobe sampled with `xfer_busy` high, and low-power entry is not blocked. A `ref_req` while idle raises no request.
- R11: `mode_upd_pending` clears at the clock edge where `mode_upd_gnt` and `mode_upd_req` are both high. A grant without a request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_done | input | 1 | Memory initialization sequence finished |
| cfg_we | input | 1 | Register write strobe, all fields written together |
| cfg_timeout | input | 2 | Idle timeout code: 00 at once, 01 short, 10 long, 11 off |
| cfg_comp | input | COMP_W | Self-refresh interval compensation |
| cfg_drive | input | DRV_W | Output drive strength |
| cfg_exit_slow | input | 1 | Power-down exit speed: 1 slow, 0 fast |
| cfg_ref_slot | input | 1 | Update slot: 0 before low-power entry, 1 with refresh |
| xfer_busy | input | 1 | A read or write transfer is in progress |
| ref_req | input | 1 | Refresh command strobe from the sequencer |
| mode_upd_gnt | input | 1 | Sequencer accepts the extended mode register write |
| mode_upd_req | output | 1 | Request for an extended mode register write |
| mode_upd_pending | output | 1 | An update is waiting to be issued |
| emr_comp | output | COMP_W | Stored compensation value for the write |
| emr_drive | output | DRV_W | Stored drive strength value for the write |
| emr_exit_slow | output | 1 | Stored exit speed value for the write |
| lp_enter | output | 1 | Enter the low-power state |

## Verification
The bench targets the exact edge on which each timeout expires: 63 against 64 idle edges, and 127 against 128. A counter that is off by one would enter a cycle early or late. It checks that a short busy pulse in the middle of an idle stretch restarts the count; a design that only paused the count would enter early. It also checks that rewriting unchanged values, or changing only the timeout, raises no update, since a naive change detector would waste mode register cycles. Finally it exercises both slot policies with the grant handshake: a design that let entry proceed with a policy-0 update still pending, or that accepted a refresh strobe during idle as a slot, would show the wrong `lp_enter` or `mode_upd_req`.

// File: rtl/lp_entry_pkg.sv
package lp_entry_pkg;

  typedef enum logic [1:0] {
    IDLE_NOW   = 2'b00,
    IDLE_SHORT = 2'b01,
    IDLE_LONG  = 2'b10,
    IDLE_OFF   = 2'b11
  } idle_code_e;

  // Number of idle clock edges required before entry for a code.
  function automatic int unsigned idle_limit(idle_code_e code,
                                             int unsigned short_n,
                                             int unsigned long_n);
    case (code)
      IDLE_SHORT: idle_limit = short_n;
      IDLE_LONG:  idle_limit = long_n;
      default:    idle_limit = 0;
    endcase
  endfunction

endpackage

// File: rtl/lp_idle_timer.sv
module lp_idle_timer
  import lp_entry_pkg::*;
#(
  parameter int unsigned SHORT_IDLE = 64,
  parameter int unsigned LONG_IDLE  = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xfer_busy,
  input  idle_code_e code,
  output logic       idle_ready
);
  localparam int unsigned CNT_W = $clog2(LONG_IDLE + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LONG_IDLE);

  logic [CNT_W-1:0] idle_cnt;
  logic [CNT_W-1:0] limit_w;

  assign limit_w = CNT_W'(idle_limit(code, SHORT_IDLE, LONG_IDLE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  idle_cnt <= '0;
    else if (xfer_busy)          idle_cnt <= '0;
    else if (idle_cnt < CNT_MAX) idle_cnt <= idle_cnt + 1'b1;
  end

  assign idle_ready = !xfer_busy && (code != IDLE_OFF) && (idle_cnt >= limit_w);

  // R3
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt <= CNT_MAX);
  // R4
  off_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code == IDLE_OFF) |-> !idle_ready);
  // R5
  busy_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy |=> (idle_cnt == '0));
endmodule

// File: rtl/lp_emr_tracker.sv
module lp_emr_tracker #(
  parameter int unsigned COMP_W = 2,
  parameter int unsigned DRV_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_done,
  input  logic              cfg_we,
  input  logic [COMP_W-1:0] cfg_comp,
  input  logic [DRV_W-1:0]  cfg_drive,
  input  logic              cfg_exit_slow,
  input  logic              ref_slot,
  input  logic              idle_ready,
  input  logic              xfer_busy,
  input  logic              ref_req,
  input  logic              gnt,
  output logic              req,
  output logic              pending,
  output logic [COMP_W-1:0] comp_q,
  output logic [DRV_W-1:0]  drive_q,
  output logic              exit_q
);
  logic fields_differ;
  logic raise_upd;
  logic take_upd;
  logic ref_arm;

  assign fields_differ = (cfg_comp != comp_q) || (cfg_drive != drive_q) ||
                         (cfg_exit_slow != exit_q);
  assign raise_upd = cfg_we && fields_differ && init_done;
  assign take_upd  = req && gnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comp_q  <= '0;
      drive_q <= '0;
      exit_q  <= 1'b1;
    end else if (cfg_we) begin
      comp_q  <= cfg_comp;
      drive_q <= cfg_drive;
      exit_q  <= cfg_exit_slow;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pending <= 1'b0;
    else if (raise_upd) pending <= 1'b1;
    else if (take_upd)  pending <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ref_arm <= 1'b0;
    else if (!pending || take_upd)  ref_arm <= 1'b0;
    else if (ref_req && xfer_busy)  ref_arm <= 1'b1;
  end

  assign req = pending && (ref_slot ? ref_arm : idle_ready);

  // R9
  req_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> pending);
  // R11
  clear_by_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> $past(gnt && req));
  // R7
  no_raise_pre_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !init_done && !pending) |=> !pending);
  // R6
  same_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !fields_differ && !pending) |=> !pending);
endmodule

// File: rtl/lp_entry_ctrl.sv
module lp_entry_ctrl
  import lp_entry_pkg::*;
#(
  parameter int unsigned COMP_W     = 2,
  parameter int unsigned DRV_W      = 2,
  parameter int unsigned SHORT_IDLE = 64,
  parameter int unsigned LONG_IDLE  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_done,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_timeout,
  input  logic [COMP_W-1:0] cfg_comp,
  input  logic [DRV_W-1:0]  cfg_drive,
  input  logic              cfg_exit_slow,
  input  logic              cfg_ref_slot,
  input  logic              xfer_busy,
  input  logic              ref_req,
  input  logic              mode_upd_gnt,
  output logic              mode_upd_req,
  output logic              mode_upd_pending,
  output logic [COMP_W-1:0] emr_comp,
  output logic [DRV_W-1:0]  emr_drive,
  output logic              emr_exit_slow,
  output logic              lp_enter
);
  idle_code_e timeout_q;
  logic       ref_slot_q;
  logic       idle_ready;
  logic       entry_blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timeout_q  <= IDLE_NOW;
      ref_slot_q <= 1'b0;
    end else if (cfg_we) begin
      timeout_q  <= idle_code_e'(cfg_timeout);
      ref_slot_q <= cfg_ref_slot;
    end
  end

  lp_idle_timer #(
    .SHORT_IDLE(SHORT_IDLE),
    .LONG_IDLE (LONG_IDLE)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_busy (xfer_busy),
    .code      (timeout_q),
    .idle_ready(idle_ready)
  );

  lp_emr_tracker #(
    .COMP_W(COMP_W),
    .DRV_W (DRV_W)
  ) u_tracker (
    .clk          (clk),
    .rst_n        (rst_n),
    .init_done    (init_done),
    .cfg_we       (cfg_we),
    .cfg_comp     (cfg_comp),
    .cfg_drive    (cfg_drive),
    .cfg_exit_slow(cfg_exit_slow),
    .ref_slot     (ref_slot_q),
    .idle_ready   (idle_ready),
    .xfer_busy    (xfer_busy),
    .ref_req      (ref_req),
    .gnt          (mode_upd_gnt),
    .req          (mode_upd_req),
    .pending      (mode_upd_pending),
    .comp_q       (emr_comp),
    .drive_q      (emr_drive),
    .exit_q       (emr_exit_slow)
  );

  assign entry_blocked = mode_upd_pending && !ref_slot_q;
  assign lp_enter      = init_done && idle_ready && !entry_blocked;

  // R5
  busy_no_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy |-> !lp_enter);
  // R9
  hold_for_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_upd_pending && !ref_slot_q) |-> !lp_enter);
  // R7
  pre_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !lp_enter);
endmodule

// File: tb/lp_entry_ctrl_bench.sv
module lp_entry_ctrl_bench;
  localparam int SHORT_N = 64;
  localparam int LONG_N  = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_done = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_timeout = 2'b00;
  logic [1:0] cfg_comp = 2'd0;
  logic [1:0] cfg_drive = 2'd0;
  logic cfg_exit_slow = 1'b1;
  logic cfg_ref_slot = 1'b0;
  logic xfer_busy = 1'b1;
  logic ref_req = 1'b0;
  logic mode_upd_gnt = 1'b0;
  logic mode_upd_req, mode_upd_pending, emr_exit_slow, lp_enter;
  logic [1:0] emr_comp, emr_drive;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  lp_entry_ctrl u_lp_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .cfg_we(cfg_we),
    .cfg_timeout(cfg_timeout), .cfg_comp(cfg_comp), .cfg_drive(cfg_drive),
    .cfg_exit_slow(cfg_exit_slow), .cfg_ref_slot(cfg_ref_slot),
    .xfer_busy(xfer_busy), .ref_req(ref_req), .mode_upd_gnt(mode_upd_gnt),
    .mode_upd_req(mode_upd_req), .mode_upd_pending(mode_upd_pending),
    .emr_comp(emr_comp), .emr_drive(emr_drive), .emr_exit_slow(emr_exit_slow),
    .lp_enter(lp_enter)
  );

  // Timeout vectors: code, idle edges, expected lp_enter
  localparam int NV = 7;
  localparam int V_CODE [NV] = '{0, 1, 1, 2, 2, 3, 1};
  localparam int V_WAIT [NV] = '{0, SHORT_N-1, SHORT_N, LONG_N-1, LONG_N, 300, 0};
  localparam int V_EXP  [NV] = '{1, 0, 1, 0, 1, 0, 0};

  task automatic chk(input int got, input int exp, input string req, input string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic wr(input int code, input int comp, input int drv, input int ex, input int slot);
    @(negedge clk);
    cfg_timeout = 2'(code); cfg_comp = 2'(comp); cfg_drive = 2'(drv);
    cfg_exit_slow = 1'(ex); cfg_ref_slot = 1'(slot); cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // busy for two edges, then idle for n edges; sampling 5 ns after last event
  task automatic idle_for(input int n);
    @(negedge clk); xfer_busy = 1'b1;
    repeat (2) @(negedge clk);
    xfer_busy = 1'b0;
    repeat (n) @(posedge clk);
    #5;
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #5;
    // R1 reset state
    chk(emr_comp, 0, "R1", "emr_comp");
    chk(emr_drive, 0, "R1", "emr_drive");
    chk(emr_exit_slow, 1, "R1", "emr_exit_slow");
    chk(mode_upd_pending, 0, "R1", "pending");
    chk(mode_upd_req, 0, "R1", "req");
    chk(lp_enter, 0, "R1", "lp_enter");
    // R7 idle before init, then pre-init write
    idle_for(5);
    chk(lp_enter, 0, "R7", "lp_enter before init");
    wr(0, 0, 2, 1, 0);
    #5;
    chk(emr_drive, 2, "R7", "drive stored pre-init");
    chk(mode_upd_pending, 0, "R7", "pending pre-init");
    init_done = 1'b1;
    // R2 immediate entry
    idle_for(0);
    chk(lp_enter, 1, "R2", "code 00 idle");
    // vector table R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      wr(V_CODE[i], 0, 2, 1, 0);
      idle_for(V_WAIT[i]);
      if (i == NV - 1) begin
        // last vector: short code, zero idle edges
        chk(lp_enter, V_EXP[i], "R3", "code 01 zero idle");
      end else if (V_CODE[i] == 3) begin
        chk(lp_enter, V_EXP[i], "R4", "code 11 long idle");
      end else begin
        chk(lp_enter, V_EXP[i], "R3", $sformatf("vector %0d", i));
      end
    end
    // R6 timeout-only and identical writes raised nothing
    chk(mode_upd_pending, 0, "R6", "no change no pending");
    // R5 busy drops entry, restart of count
    wr(0, 0, 2, 1, 0);
    idle_for(3);
    @(negedge clk); xfer_busy = 1'b1; #5;
    chk(lp_enter, 0, "R5", "busy drops entry");
    wr(1, 0, 2, 1, 0);
    idle_for(40);
    @(negedge clk); xfer_busy = 1'b1;
    @(negedge clk); xfer_busy = 1'b0;
    repeat (40) @(posedge clk); #5;
    chk(lp_enter, 0, "R5", "count restarted");
    repeat (SHORT_N - 40) @(posedge clk); #5;
    chk(lp_enter, 1, "R5", "full count after restart");
    // R6 R8 merge of two changes, policy 0
    wr(0, 1, 2, 1, 0);
    #5;
    chk(mode_upd_pending, 1, "R6", "change raises pending");
    @(negedge clk); xfer_busy = 1'b1;
    wr(0, 1, 3, 0, 0);
    #5;
    chk(emr_comp, 1, "R8", "latest comp");
    chk(emr_drive, 3, "R8", "latest drive");
    chk(emr_exit_slow, 0, "R8", "latest exit");
    chk(mode_upd_req, 0, "R9", "no req while busy");
    // R9 timeout met: request, entry held
    @(negedge clk); xfer_busy = 1'b0; #5;
    chk(mode_upd_req, 1, "R9", "req at timeout");
    chk(lp_enter, 0, "R9", "entry held");
    @(negedge clk); mode_upd_gnt = 1'b1;
    @(posedge clk); #5;
    mode_upd_gnt = 1'b0;
    chk(mode_upd_pending, 0, "R11", "grant clears");
    chk(lp_enter, 1, "R9", "entry after grant");
    // R11 grant without request ignored
    @(negedge clk); xfer_busy = 1'b1;
    wr(0, 2, 3, 0, 0);
    @(negedge clk); mode_upd_gnt = 1'b1;
    @(posedge clk); #5;
    mode_upd_gnt = 1'b0;
    chk(mode_upd_pending, 1, "R11", "grant without req");
    @(negedge clk); xfer_busy = 1'b0;
    @(negedge clk); mode_upd_gnt = 1'b1;
    @(posedge clk); #5;
    mode_upd_gnt = 1'b0;
    chk(mode_upd_pending, 0, "R11", "grant with req");
    // R10 policy 1
    wr(0, 2, 3, 1, 1);
    #5;
    chk(mode_upd_pending, 1, "R10", "pending set");
    chk(lp_enter, 1, "R10", "entry not blocked");
    chk(mode_upd_req, 0, "R10", "no req without refresh");
    @(negedge clk); ref_req = 1'b1;
    @(negedge clk); ref_req = 1'b0; #5;
    chk(mode_upd_req, 0, "R10", "idle refresh ignored");
    @(negedge clk); xfer_busy = 1'b1; ref_req = 1'b1;
    @(negedge clk); ref_req = 1'b0; #5;
    chk(mode_upd_req, 1, "R10", "req with busy refresh");
    @(negedge clk); mode_upd_gnt = 1'b1;
    @(posedge clk); #5;
    mode_upd_gnt = 1'b0;
    chk(mode_upd_pending, 0, "R11", "policy 1 grant clears");
    chk(mode_upd_req, 0, "R11", "req drops after grant");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule